// File: doc/BRIEF.md
# Shift and Logic Execute Unit

This block is the combinational execute stage for register-to-register operations. It takes two 32-bit operands, a 5-bit shift count and a 6-bit operation selector, and in the same cycle returns a 32-bit result, a flag saying whether the selector named a supported operation, and a flag that is high when the result is all zeros.

Six operations are supported: wrapping addition, wrapping subtraction, bitwise AND, logical left shift, logical right shift and one's complement. The shifts and the complement act on operand B only. Operand A is not used for them. Address arithmetic for loads, stores and immediate adds can drive the addition path with a base register and a sign-extended offset. The shifter can be built as explicit power-of-two stages or as a plain shift operator, chosen by a parameter.

Top module: `rr_exec_unit`

## Requirements
- R1: Selector value 32 (6'b100000) gives `opnd_a + opnd_b` modulo 2^32, with no overflow indication.
- R2: Selector value 34 (6'b100010) gives `opnd_a - opnd_b` modulo 2^32, so B is taken from A.
- R3: Selector value 36 (6'b100100) gives the bitwise AND of both operands.
- R4: Selector value 1 (6'b000001) gives `opnd_b` shifted left by `shamt`, with zeros filling the low bits; `opnd_a` has no effect.
- R5: Selector value 2 (6'b000010) gives `opnd_b` shifted right by `shamt`, with zeros filling the high bits; `opnd_a` has no effect.
- R6: Selector value 8 (6'b001000) gives the bitwise inverse of `opnd_b`; `opnd_a` and `shamt` have no effect.
- R7: `valid` is 1 for the six selector values 1, 2, 8, 32, 34 and 36.
- R8: For every other selector value, `result` is 0 and `valid` is 0.
- R9: `zero` is 1 exactly when `result` is 0, whatever the selector is.
- R10: `shamt` has no effect on the result of selector values 32, 34 and 36.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First source operand |
| opnd_b | input | 32 | Second source operand, the only data input of shifts and complement |
| shamt | input | 5 | Shift count for the two shift operations |
| fcode | input | 6 | Operation selector |
| result | output | 32 | Operation output |
| valid | output | 1 | Selector named a supported operation |
| zero | output | 1 | Result equals zero |

## Verification
The bench goes after carry and borrow wrap at the 32-bit edge: a unit that saturated or kept a 33rd bit would return the wrong sum of 0xFFFFFFFF and 1, or the wrong difference of 0 and 1. It shifts by 0 and by 31 and fills B with ones, so a right shift that copied the sign bit, or a stage that was wired the wrong way, shows up in the high bits. It drives operand A with all ones and with zero under shifts and complement, and varies `shamt` under add, subtract and AND, to catch an input that leaks into a path that must not use it. It sweeps all 64 selector values so that a decoder that accepted a neighbouring code, or let a stale result through with `valid` low, is reported.

// File: rtl/rr_exec_pkg.sv
package rr_exec_pkg;
   localparam int FC_W = 6;

   localparam logic [FC_W-1:0] FC_SHL  = 6'd1;
   localparam logic [FC_W-1:0] FC_SHR  = 6'd2;
   localparam logic [FC_W-1:0] FC_INV  = 6'd8;
   localparam logic [FC_W-1:0] FC_ADD  = 6'd32;
   localparam logic [FC_W-1:0] FC_SUB  = 6'd34;
   localparam logic [FC_W-1:0] FC_AND  = 6'd36;

   typedef enum logic [2:0] {
      SEL_NONE = 3'd0,
      SEL_ARITH = 3'd1,
      SEL_AND  = 3'd2,
      SEL_SHL  = 3'd3,
      SEL_SHR  = 3'd4,
      SEL_INV  = 3'd5
   } sel_e;
endpackage

// File: rtl/rr_exec_addsub.sv
module rr_exec_addsub #(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] y
);
   logic [W-1:0] b_eff;
   logic [W-1:0] cin_vec;

   assign b_eff   = b ^ {W{sub}};
   assign cin_vec = {{(W-1){1'b0}}, sub};
   assign y       = a + b_eff + cin_vec;
endmodule

// File: rtl/rr_exec_shift.sv
module rr_exec_shift #(
   parameter int W        = 32,
   parameter int SH_W     = 5,
   parameter bit TO_LEFT  = 1'b1,
   parameter int STYLE    = 0
) (
   input  logic [W-1:0]    din,
   input  logic [SH_W-1:0] amt,
   output logic [W-1:0]    dout
);
   generate
      if (STYLE == 0) begin : g_staged
         logic [W-1:0] stg [0:SH_W];
         assign stg[0] = din;
         for (genvar i = 0; i < SH_W; i++) begin : g_stage
            if (TO_LEFT) begin : g_l
               assign stg[i+1] = amt[i] ? (stg[i] << (1 << i)) : stg[i];
            end else begin : g_r
               assign stg[i+1] = amt[i] ? (stg[i] >> (1 << i)) : stg[i];
            end
         end
         assign dout = stg[SH_W];
      end else begin : g_operator
         if (TO_LEFT) begin : g_l
            assign dout = din << amt;
         end else begin : g_r
            assign dout = din >> amt;
         end
      end
   endgenerate
endmodule

// File: rtl/rr_exec_decode.sv
module rr_exec_decode
   import rr_exec_pkg::*;
(
   input  logic [FC_W-1:0] fcode,
   output sel_e            sel,
   output logic            sub
);
   always_comb begin
      sel = SEL_NONE;
      sub = 1'b0;
      case (fcode)
         FC_ADD: sel = SEL_ARITH;
         FC_SUB: begin
            sel = SEL_ARITH;
            sub = 1'b1;
         end
         FC_AND: sel = SEL_AND;
         FC_SHL: sel = SEL_SHL;
         FC_SHR: sel = SEL_SHR;
         FC_INV: sel = SEL_INV;
         default: sel = SEL_NONE;
      endcase
   end
endmodule

// File: rtl/rr_exec_unit.sv
module rr_exec_unit
   import rr_exec_pkg::*;
#(
   parameter int W           = 32,
   parameter int SHIFT_STYLE = 0
) (
   input  logic [W-1:0]         opnd_a,
   input  logic [W-1:0]         opnd_b,
   input  logic [$clog2(W)-1:0] shamt,
   input  logic [FC_W-1:0]      fcode,
   output logic [W-1:0]         result,
   output logic                 valid,
   output logic                 zero
);
   localparam int SH_W = $clog2(W);

   generate
      if (W < 8) begin : g_chk_w
         $error("rr_exec_unit: W must be at least 8");
      end
      if ((1 << SH_W) != W) begin : g_chk_pow2
         $error("rr_exec_unit: W must be a power of two");
      end
      if (SHIFT_STYLE < 0 || SHIFT_STYLE > 1) begin : g_chk_style
         $error("rr_exec_unit: SHIFT_STYLE must be 0 or 1");
      end
   endgenerate

   sel_e         sel;
   logic         do_sub;
   logic [W-1:0] arith_y;
   logic [W-1:0] shl_y;
   logic [W-1:0] shr_y;

   rr_exec_decode u_dec (
      .fcode (fcode),
      .sel   (sel),
      .sub   (do_sub)
   );

   rr_exec_addsub #(.W(W)) u_arith (
      .a   (opnd_a),
      .b   (opnd_b),
      .sub (do_sub),
      .y   (arith_y)
   );

   rr_exec_shift #(.W(W), .SH_W(SH_W), .TO_LEFT(1'b1), .STYLE(SHIFT_STYLE)) u_shl (
      .din  (opnd_b),
      .amt  (shamt),
      .dout (shl_y)
   );

   rr_exec_shift #(.W(W), .SH_W(SH_W), .TO_LEFT(1'b0), .STYLE(SHIFT_STYLE)) u_shr (
      .din  (opnd_b),
      .amt  (shamt),
      .dout (shr_y)
   );

   always_comb begin
      unique case (sel)
         SEL_ARITH: result = arith_y;
         SEL_AND:   result = opnd_a & opnd_b;
         SEL_SHL:   result = shl_y;
         SEL_SHR:   result = shr_y;
         SEL_INV:   result = ~opnd_b;
         default:   result = '0;
      endcase
   end

   assign valid = (sel != SEL_NONE);
   assign zero  = ~|result;
endmodule

// File: rtl/rr_exec_unit_chk.sv
module rr_exec_unit_chk
   import rr_exec_pkg::*;
#(
   parameter int W = 32
) (
   input logic [W-1:0]         opnd_a,
   input logic [W-1:0]         opnd_b,
   input logic [$clog2(W)-1:0] shamt,
   input logic [FC_W-1:0]      fcode,
   input logic [W-1:0]         result,
   input logic                 valid,
   input logic                 zero
);
   always_comb begin
      if (!$isunknown({opnd_a, opnd_b, shamt, fcode})) begin
         if (fcode == FC_ADD) begin
            AST_ADD_INVERSE: assert ((result - opnd_b) == opnd_a); // R1
         end
         if (fcode == FC_SUB) begin
            AST_SUB_INVERSE: assert ((result + opnd_b) == opnd_a); // R2
         end
         if (fcode == FC_AND) begin
            AST_AND_SUBSET: assert (((result & ~opnd_a) == '0) && ((result & ~opnd_b) == '0)); // R3
         end
         if (fcode == FC_SHL && shamt != '0) begin
            AST_SHL_LOW_FILL: assert (result[0] == 1'b0); // R4
         end
         if (fcode == FC_SHR && shamt != '0) begin
            AST_SHR_HIGH_FILL: assert (result[W-1] == 1'b0); // R5
         end
         if (fcode == FC_INV) begin
            AST_INV_COMPLEMENT: assert ((result ^ opnd_b) == '1); // R6
         end
         if (!valid) begin
            AST_BAD_CODE_ZERO: assert (result == '0 && zero); // R8
         end
         if (fcode == FC_INV && zero) begin
            AST_ZERO_INV_ONES: assert (opnd_b == '1); // R9
         end
      end
   end
endmodule

bind rr_exec_unit rr_exec_unit_chk #(.W(W)) u_chk (
   .opnd_a (opnd_a),
   .opnd_b (opnd_b),
   .shamt  (shamt),
   .fcode  (fcode),
   .result (result),
   .valid  (valid),
   .zero   (zero)
);

// File: tb/sim_rr_exec_unit.sv
`timescale 1ns/1ps
module sim_rr_exec_unit;
   localparam int W = 32;
   localparam int S = 5;

   logic         clk = 1'b0;
   logic [W-1:0] a = '0;
   logic [W-1:0] b = '0;
   logic [S-1:0] sh = '0;
   logic [5:0]   fc = '0;
   logic [W-1:0] res;
   logic         vld;
   logic         zf;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   rr_exec_unit #(.W(W), .SHIFT_STYLE(0)) u0 (
      .opnd_a (a),
      .opnd_b (b),
      .shamt  (sh),
      .fcode  (fc),
      .result (res),
      .valid  (vld),
      .zero   (zf)
   );

   function automatic logic [W:0] ref_op(logic [W-1:0] x, logic [W-1:0] y,
                                         logic [S-1:0] s, logic [5:0] f);
      case (f)
         6'd32:   return {1'b1, x + y};
         6'd34:   return {1'b1, x - y};
         6'd36:   return {1'b1, x & y};
         6'd1:    return {1'b1, y << s};
         6'd2:    return {1'b1, y >> s};
         6'd8:    return {1'b1, ~y};
         default: return {1'b0, {W{1'b0}}};
      endcase
   endfunction

   function automatic string tag_of(logic [5:0] f);
      case (f)
         6'd32:   return "R1";
         6'd34:   return "R2";
         6'd36:   return "R3";
         6'd1:    return "R4";
         6'd2:    return "R5";
         6'd8:    return "R6";
         default: return "R8";
      endcase
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   task automatic cmp(string tag, logic [W-1:0] got, logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h (a=%h b=%h sh=%0d fc=%0d)",
                  tag, got, exp, a, b, sh, fc);
      end
   endtask

   task automatic apply(logic [W-1:0] x, logic [W-1:0] y, logic [S-1:0] s, logic [5:0] f);
      logic [W:0] e;
      @(negedge clk);
      a = x; b = y; sh = s; fc = f;
      #1;
      e = ref_op(x, y, s, f);
      cmp(tag_of(f), res, e[W-1:0]);
      cmp(e[W] ? "R7" : "R8", {{(W-1){1'b0}}, vld}, {{(W-1){1'b0}}, e[W]});
      cmp("R9", {{(W-1){1'b0}}, zf}, {{(W-1){1'b0}}, (e[W-1:0] == '0)});
   endtask

   initial begin
      #(200000 * 4);
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [5:0]   codes [6];
      logic [W-1:0] keep;
      void'($urandom(32'h5EED_0042));
      codes[0] = 6'd32; codes[1] = 6'd34; codes[2] = 6'd36;
      codes[3] = 6'd1;  codes[4] = 6'd2;  codes[5] = 6'd8;

      // reset-like idle state: all inputs zero, selector 0 unsupported
      #1;
      cmp("R8", res, '0);
      cmp("R8", {31'd0, vld}, 32'd0);
      cmp("R9", {31'd0, zf}, 32'd1);

      // R1 / R2 wrap at the word edge
      apply(32'hFFFF_FFFF, 32'h1, 5'd0, 6'd32);
      apply(32'h0, 32'h1, 5'd0, 6'd34);
      apply(32'h8000_0000, 32'h8000_0000, 5'd3, 6'd32);
      apply(32'h1234_5678, 32'h1234_5678, 5'd9, 6'd34);
      // R3
      apply(32'hF0F0_F0F0, 32'h0FF0_0FF0, 5'd7, 6'd36);
      // R4 / R5 boundary counts and zero fill
      apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0,  6'd1);
      apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd31, 6'd1);
      apply(32'h0, 32'hFFFF_FFFF, 5'd31, 6'd2);
      apply(32'hFFFF_FFFF, 32'h8000_0000, 5'd1, 6'd2);
      // R6
      apply(32'h0, 32'hFFFF_FFFF, 5'd17, 6'd8);
      apply(32'hDEAD_BEEF, 32'h0, 5'd0, 6'd8);

      // R4 R5 R6: operand A has no effect
      for (int k = 3; k < 6; k++) begin
         apply(32'h0, 32'hA5C3_0F81, 5'd5, codes[k]);
         keep = res;
         apply(32'hFFFF_FFFF, 32'hA5C3_0F81, 5'd5, codes[k]);
         cmp("R4_R5_R6_opnd_a_ignored", res, keep);
      end

      // R10: shift count has no effect on add, subtract, AND
      for (int k = 0; k < 3; k++) begin
         apply(32'h7654_3210, 32'h89AB_CDEF, 5'd0, codes[k]);
         keep = res;
         apply(32'h7654_3210, 32'h89AB_CDEF, 5'd31, codes[k]);
         cmp("R10", res, keep);
      end

      // R7 / R8 full selector sweep
      for (int f = 0; f < 64; f++) begin
         apply(32'h1357_9BDF, 32'h0246_8ACE, 5'd4, f[5:0]);
      end

      // random mix
      for (int n = 0; n < 400; n++) begin
         logic [5:0] f;
         if (($urandom % 8) == 0) f = 6'($urandom);
         else                     f = codes[$urandom % 6];
         apply($urandom, $urandom, 5'($urandom), f);
      end

      finish_run();
   end
endmodule